// File: doc/BRIEF.md
# Conversion Capture Buffer with Pass-Through Mode

This block sits between a data converter's result path and an output register. Each conversion result is an 18-bit word: 16 data bits, a copy of the most significant bit, and an overflow flag. A mode input picks one of two paths. In pass-through mode each new result goes straight to the output. In buffered mode every completed result is written into a 16-deep first-word-fall-through store, and no write command is needed. When the store is empty, the first word written appears on the output at once.

An asynchronous read line steps the output through the stored words. The line idles high. Each rising edge presents the next older word. When only one word remains, the next falling edge of the line marks the store empty and leaves that word on the output. Two status outputs encode the fill level. Holding the mode input at pass-through while the read line is low clears the store to empty.

Top module: `sample_fifo_bypass`

## Requirements
- R1: The output word keeps its field layout: `q_data` carries the 16 data bits, `q_msb` the MSB copy and `q_ovf` the overflow flag, exactly as they were written.
- R2: With `buf_mode`=0, the output shows the most recent conversion word one clock after its `conv_valid` cycle.
- R3: With `buf_mode`=0, conversions do not enter the store. Stored words and their count are unchanged on return to `buf_mode`=1, provided the read line stayed high.
- R4: With `buf_mode`=1 and the store empty, a written word appears on the output one clock after its `conv_valid` cycle.
- R5: The store accepts at most 16 words. A write arriving while it holds 16 is dropped, and so is every later write until a word is removed.
- R6: In buffered mode, a rising edge on `rd_line` while two or more words are held removes the oldest word and presents the next one.
- R7: In buffered mode, a falling edge on `rd_line` while exactly one word is held empties the store and leaves that word on the output.
- R8: A read edge while the store is empty leaves the output word unchanged.
- R9: `buf_mode`=0 together with a low `rd_line` (after synchronisation) clears the store to empty. The output word is not altered by the clear.
- R10: Status encoding as {`stat_full`,`stat_edge`}: empty = 01, holding 1 to 15 words = 00, full (16 words) = 11. The code 10 never occurs.
- R11: A write and a word removal in the same clock cycle leave the word count unchanged.
- R12: `rd_line` passes through a two-stage synchroniser. A single rising edge removes at most one word, however long the line then stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| buf_mode | input | 1 | 1 = buffered path, 0 = pass-through |
| rd_line | input | 1 | Asynchronous read line, idles high |
| conv_valid | input | 1 | One-cycle pulse when a conversion result is ready |
| conv_data | input | 16 | Conversion data bits |
| conv_msb | input | 1 | MSB copy of the result |
| conv_ovf | input | 1 | Overflow flag of the result |
| q_data | output | 16 | Output data bits |
| q_msb | output | 1 | Output MSB copy |
| q_ovf | output | 1 | Output overflow flag |
| stat_full | output | 1 | Status bit, high only when full |
| stat_edge | output | 1 | Status bit, high when empty or full |

## Verification
A pointer or count error shows at the ports within one read step, because the output presents the wrong older word. It also shows within one write, because the status fails to reach or leave the full and empty codes at the expected word. An error in the last-word rule shows as a changed output when a read edge arrives at an empty store. An error in the same-cycle write/remove count shows only later, when draining the store empties it one word early or one word late. The bench therefore drains the store completely after each such event.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
  // Status code {full_bit, edge_bit}: empty 01, partial 00, full 11.
  function automatic logic [1:0] fill_code(input int unsigned cnt, input int unsigned depth);
    logic [1:0] c;
    if (cnt == 0)          c = 2'b01;
    else if (cnt >= depth) c = 2'b11;
    else                   c = 2'b00;
    return c;
  endfunction

  // Wrapping pointer step that does not need a power-of-two depth.
  function automatic int unsigned ptr_step(input int unsigned p, input int unsigned depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/sfb_rd_sync.sv
module sfb_rd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_async,
  output logic line_lvl,
  output logic line_rise,
  output logic line_fall
);
  logic [STAGES-1:0] chain;
  logic              last_lvl;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= line_async;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= 1'b1;
          else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) last_lvl <= 1'b1;
    else        last_lvl <= chain[STAGES-1];

  assign line_lvl  = chain[STAGES-1];
  assign line_rise = chain[STAGES-1] & ~last_lvl;
  assign line_fall = ~chain[STAGES-1] & last_lvl;

  // R12: an edge pulse never lasts two cycles
  a_r12_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    line_rise |=> !line_rise);
endmodule

// File: rtl/sfb_store.sv
module sfb_store #(
  parameter int WORD_W = 18,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_req,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rd_rise,
  input  logic              rd_fall,
  output logic [WORD_W-1:0] head_word,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  import sfb_pkg::*;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [CW-1:0] ONE_C  = CW'(1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr, rd_nxt, wr_nxt;

  // Named internal events
  logic wr_acc, adv, drain, pop, load_new;
  assign wr_acc   = wr_req && !clr && (count != FULL_C);
  assign adv      = rd_rise && !clr && (count > ONE_C);
  assign drain    = rd_fall && !clr && (count == ONE_C);
  assign pop      = adv || drain;
  assign load_new = wr_acc && ((count == '0) || drain);
  assign rd_nxt   = AW'(ptr_step(int'(rd_ptr), DEPTH));
  assign wr_nxt   = AW'(ptr_step(int'(wr_ptr), DEPTH));

  always_ff @(posedge clk)
    if (wr_acc) mem[wr_ptr] <= wr_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_acc) wr_ptr <= wr_nxt;
      if (pop)    rd_ptr <= rd_nxt;
      count <= count + (wr_acc ? ONE_C : '0) - (pop ? ONE_C : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        head_word <= '0;
    else if (adv)      head_word <= mem[rd_nxt];
    else if (load_new) head_word <= wr_word;
  end

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_C);
  a_r4_fall_through: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !clr && count == '0) |=> head_word == $past(wr_word));
  a_r8_hold_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !wr_req) |=> $stable(head_word));
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count == '0);
  a_r11_net_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && pop) |=> count == $past(count));
  a_r5_drop_full: assert property (@(posedge clk) disable iff (!rst_n)
    (count == FULL_C && !rd_rise && !clr) |=> count == FULL_C);
endmodule

// File: rtl/sfb_status.sv
module sfb_status #(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       stat_full,
  output logic                       stat_edge
);
  import sfb_pkg::*;
  logic [1:0] code;
  assign code      = fill_code(int'(count), DEPTH);
  assign stat_full = code[1];
  assign stat_edge = code[0];

  // R10: unused code never produced
  a_r10_code_unused: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat_full && !stat_edge));
endmodule

// File: rtl/sample_fifo_bypass.sv
module sample_fifo_bypass #(
  parameter int DATA_W      = 16,
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              buf_mode,
  input  logic              rd_line,
  input  logic              conv_valid,
  input  logic [DATA_W-1:0] conv_data,
  input  logic              conv_msb,
  input  logic              conv_ovf,
  output logic [DATA_W-1:0] q_data,
  output logic              q_msb,
  output logic              q_ovf,
  output logic              stat_full,
  output logic              stat_edge
);
  localparam int WORD_W = DATA_W + 2;
  localparam int CW     = $clog2(DEPTH+1);

  logic              rd_lvl, rd_rise, rd_fall;
  logic              fifo_clr, fifo_wr, fifo_rise, fifo_fall;
  logic [WORD_W-1:0] in_word, head_word, pass_word, out_word;
  logic [CW-1:0]     count;

  assign in_word = {conv_ovf, conv_msb, conv_data};

  sfb_rd_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
    .clk(clk), .rst_n(rst_n), .line_async(rd_line),
    .line_lvl(rd_lvl), .line_rise(rd_rise), .line_fall(rd_fall));

  // Commands are gated off in pass-through; that mode plus a low line clears.
  assign fifo_clr  = !buf_mode && !rd_lvl;
  assign fifo_wr   = buf_mode && conv_valid;
  assign fifo_rise = buf_mode && rd_rise;
  assign fifo_fall = buf_mode && rd_fall;

  sfb_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .wr_req(fifo_wr),
    .wr_word(in_word), .rd_rise(fifo_rise), .rd_fall(fifo_fall),
    .head_word(head_word), .count(count));

  sfb_status #(.DEPTH(DEPTH)) u_status (
    .clk(clk), .rst_n(rst_n), .count(count),
    .stat_full(stat_full), .stat_edge(stat_edge));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          pass_word <= '0;
    else if (conv_valid) pass_word <= in_word;

  assign out_word = buf_mode ? head_word : pass_word;
  assign q_data   = out_word[DATA_W-1:0];
  assign q_msb    = out_word[DATA_W];
  assign q_ovf    = out_word[DATA_W+1];

  a_r2_direct_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (!buf_mode && conv_valid) |=> (buf_mode || {q_ovf, q_msb, q_data} == $past(in_word)));
  a_r3_direct_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_mode |=> count <= $past(count));
endmodule

// File: tb/test_sample_fifo_bypass.sv
`timescale 1ns/1ps
module test_sample_fifo_bypass;
  logic        clk = 0, rst_n = 0;
  logic        buf_mode = 0, rd_line = 1, conv_valid = 0;
  logic [15:0] conv_data = 0;
  logic        conv_msb = 0, conv_ovf = 0;
  logic [15:0] q_data;
  logic        q_msb, q_ovf, stat_full, stat_edge;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  logic [17:0] exp_q[$];
  logic [17:0] last_word = '0;
  logic [17:0] pass_last = '0;

  always #10 clk = ~clk;

  sample_fifo_bypass i_sample_fifo_bypass (
    .clk(clk), .rst_n(rst_n), .buf_mode(buf_mode), .rd_line(rd_line),
    .conv_valid(conv_valid), .conv_data(conv_data), .conv_msb(conv_msb),
    .conv_ovf(conv_ovf), .q_data(q_data), .q_msb(q_msb), .q_ovf(q_ovf),
    .stat_full(stat_full), .stat_edge(stat_edge));

  function automatic logic [1:0] exp_status(int n);
    if (n == 0)  return 2'b01;
    if (n >= 16) return 2'b11;
    return 2'b00;
  endfunction

  function automatic logic [17:0] exp_out();
    if (!buf_mode) return pass_last;
    if (exp_q.size() > 0) return exp_q[0];
    return last_word;
  endfunction

  task automatic check_out(string req);
    logic [17:0] act, exp;
    act = {q_ovf, q_msb, q_data};
    exp = exp_out();
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: output actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_stat(string req);
    logic [1:0] exp;
    exp = exp_status(exp_q.size());
    n_checks++;
    if ({stat_full, stat_edge} !== exp) begin
      n_fail++;
      $display("FAIL %s: status actual %b expected %b", req, {stat_full, stat_edge}, exp);
    end
  endtask

  // Driver: presents one conversion and pushes what the store should hold.
  task automatic convert(logic [17:0] w);
    @(negedge clk);
    {conv_ovf, conv_msb, conv_data} = w;
    conv_valid = 1;
    @(negedge clk);
    conv_valid = 0;
    pass_last = w;
    if (buf_mode) begin
      if (exp_q.size() == 0) last_word = w;
      if (exp_q.size() < 16) exp_q.push_back(w);
    end
    @(negedge clk);
  endtask

  task automatic model_fall();
    if (buf_mode && exp_q.size() == 1) begin
      last_word = exp_q[0];
      void'(exp_q.pop_front());
    end
  endtask

  task automatic model_rise();
    if (buf_mode && exp_q.size() >= 2) void'(exp_q.pop_front());
    if (buf_mode && exp_q.size() > 0) last_word = exp_q[0];
  endtask

  // Read step: line low, then high for hi_len cycles.
  task automatic read_pulse(int hi_len);
    @(negedge clk);
    rd_line = 0;
    repeat (5) @(negedge clk);
    model_fall();
    rd_line = 1;
    repeat (hi_len) @(negedge clk);
    model_rise();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_stat("R10 reset empty");
    check_out("R2 reset output");

    // Pass-through
    convert(18'h2_1234); check_out("R2 direct A");
    convert(18'h1_ABCD); check_out("R1 R2 direct B");

    // Buffered fill with overflow of 4 words
    @(negedge clk); buf_mode = 1; @(negedge clk);
    check_stat("R10 empty before fill");
    for (int i = 0; i < 20; i++) begin
      convert({i[1:0], 16'h1000 + 16'(i * 3)});
      if (i == 0) begin check_out("R4 first word falls through"); check_stat("R10 partial"); end
    end
    check_stat("R5 full after 20 writes");
    check_out("R5 head is oldest");

    // Drain: 15 presenting steps, then the emptying step
    for (int k = 0; k < 15; k++) begin
      read_pulse((k == 3) ? 30 : 5);
      check_out(k == 3 ? "R12 long high one step" : "R6 next word");
    end
    check_stat("R10 one word left partial");
    read_pulse(5);
    check_stat("R7 empty after last fall");
    check_out("R5 R7 sixteenth word retained");
    read_pulse(5);
    check_out("R8 read when empty");
    check_stat("R8 still empty");

    // Pass-through does not touch stored words
    convert(18'h0_0A01); convert(18'h3_0A02); convert(18'h1_0A03);
    check_out("R1 head field layout");
    @(negedge clk); buf_mode = 0; @(negedge clk);
    convert(18'h2_D001); convert(18'h0_D002);
    check_out("R2 direct during hold");
    @(negedge clk); buf_mode = 1; @(negedge clk);
    check_out("R3 head kept");
    check_stat("R3 count kept");

    // Write in the same cycle as a removal (count 3 stays 3)
    @(negedge clk); rd_line = 0;
    repeat (5) @(negedge clk);
    rd_line = 1;
    @(negedge clk); @(negedge clk);
    {conv_ovf, conv_msb, conv_data} = 18'h1_E0E0;
    conv_valid = 1;
    @(negedge clk);
    conv_valid = 0;
    void'(exp_q.pop_front());
    exp_q.push_back(18'h1_E0E0);
    pass_last = 18'h1_E0E0;
    repeat (3) @(negedge clk);
    check_out("R11 next word after combined cycle");
    read_pulse(5); check_out("R11 drain 1");
    read_pulse(5); check_out("R11 drain 2"); check_stat("R11 one left");
    read_pulse(5); check_stat("R11 empty at expected step");

    // Clear by mode plus low read line
    convert(18'h0_5151); convert(18'h0_5252); convert(18'h0_5353);
    @(negedge clk); buf_mode = 0; rd_line = 0;
    repeat (5) @(negedge clk);
    rd_line = 1;
    repeat (4) @(negedge clk);
    last_word = exp_q[0];
    exp_q.delete();
    buf_mode = 1;
    @(negedge clk);
    check_stat("R9 cleared to empty");
    check_out("R9 output kept by clear");
    convert(18'h3_7777);
    check_out("R9 R4 fresh word after clear");

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule